// File: doc/BRIEF.md
# Load Bypass Predictor with Collision Check

This block decides, for each load leaving the scheduler, whether it may run ahead of older stores whose addresses are not yet known. A table of small saturating counters is indexed by a folded hash of the load's instruction pointer. A load gets permission to bypass only when its counter is at its maximum. A per-slot status array follows every load in flight. It records whether the load met an unknown store, whether it really bypassed one, and whether a store that resolved later turned out to hit the same 8-byte block.

Store addresses arrive on a broadcast port as they resolve. Each one carries a mask of the load slots that are younger than that store, and the block compares the address against every younger load that has already executed. At retirement the table learns from the load: a clean bypass opportunity counts up, and any collision clears the counter. A load that bypassed and then collided raises a one-cycle flush request.

A watchdog counts restarts over fixed windows of retired loads. If restarts are too frequent, it withholds all permissions for the whole next window.

Top module: `ld_bypass_pred`

## Requirements
- R1: After reset, every counter is zero, every status bit is clear, `flush_o` and `wd_disable_o` are low, and `disp_go_o` is low.
- R2: The table index is `disp_ip_i[7:0] ^ disp_ip_i[15:8]`. Two loads with different pointers but the same index share one counter.
- R3: `disp_go_o` is high in the same cycle as the lookup only when the indexed 4-bit counter equals 15 and the watchdog is not disabling. `disp_block_o` equals `disp_unk_i & ~disp_go_o`.
- R4: In the slot given by `disp_lb_idx_i`, a dispatch with `disp_unk_i` set sets the update bit (`lb_upd_o`). A dispatch that also has go sets the done bit (`lb_done_o`), and `lb_allow_o` records go. A retire clears every bit of that slot.
- R5: A store broadcast sets the reset bit (`lb_rst_o`) of slot i only when slot i has executed (was dispatched without block), bit i of `st_younger_i` is set, and the block address matches. A slot that is blocked, not marked younger, or at another block is left unchanged.
- R6: Retiring a load whose update bit is set and whose reset bit is clear increments its counter, saturating at 15.
- R7: Retiring a load whose update bit and reset bit are both set clears its counter to zero, whether or not its done bit is set.
- R8: Retiring a load whose update bit is clear leaves the table unchanged.
- R9: Retiring a load with done and reset both set drives `flush_o` high for exactly the next cycle and clears the whole status array. A load that collided without bypassing causes no flush.
- R10: Retired loads are grouped in windows of 1024. If more than 8 flushes occur within one window, `wd_disable_o` is high for the whole next window. Exactly 8 flushes leave it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_valid_i | input | 1 | Load dispatch this cycle |
| disp_lb_idx_i | input | 4 | Load-buffer slot of the dispatching load |
| disp_ip_i | input | 16 | Low instruction-pointer bits of the load |
| disp_blk_i | input | 29 | 8-byte block address of the load |
| disp_unk_i | input | 1 | An older store has an unresolved address |
| disp_go_o | output | 1 | Bypass permitted |
| disp_block_o | output | 1 | Load must wait for older store addresses |
| st_valid_i | input | 1 | Store address resolved this cycle |
| st_blk_i | input | 29 | 8-byte block address of the store |
| st_younger_i | input | 16 | Slots holding loads younger than the store |
| ret_valid_i | input | 1 | Load retires this cycle |
| ret_lb_idx_i | input | 4 | Slot of the retiring load |
| flush_o | output | 1 | Restart request from the retired load |
| lb_upd_o | output | 16 | Update bit per slot |
| lb_done_o | output | 16 | Done (bypassed) bit per slot |
| lb_rst_o | output | 16 | Collision bit per slot |
| lb_allow_o | output | 16 | Recorded go per slot |
| wd_disable_o | output | 1 | Watchdog is suppressing go |

## Verification
The hardest state to reach is a watchdog window that holds more than eight genuine restarts. Each restart needs a counter that has been trained fifteen times to saturation, then a bypassing dispatch, a colliding store and a retire. The bench therefore counts every retire it issues and pads with neutral loads that carry no update to the next window edge. It then plays whole windows holding exactly eight and then nine restart sequences on a dedicated pointer, and checks the disable output just after each edge. A third window confirms that a saturated entry is refused while the disable is in force and granted again once it lifts.

// File: rtl/ldp_pkg.sv
package ldp_pkg;
  typedef struct packed {
    logic vld;
    logic exec;
    logic allow;
    logic upd;
    logic done;
    logic rst;
  } lb_flags_t;
endpackage

// File: rtl/ldp_table.sv
module ldp_table #(
  parameter int N_ENTRIES = 256,
  parameter int CNT_W     = 4,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             sat_o,
  input  logic             wr_en_i,
  input  logic             wr_clr_i,
  input  logic [IDX_W-1:0] wr_idx_i
);
  logic [CNT_W-1:0] cnt_q [N_ENTRIES];

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q[i] <= '0;
      end else if (wr_en_i && wr_idx_i == IDX_W'(i)) begin
        if (wr_clr_i)          cnt_q[i] <= '0;
        else if (!(&cnt_q[i])) cnt_q[i] <= cnt_q[i] + 1'b1;
      end
    end
  end

  assign sat_o = &cnt_q[rd_idx_i];
endmodule

// File: rtl/ldp_lbuf.sv
module ldp_lbuf
  import ldp_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int BLK_W  = 29,
  parameter int IDX_W  = 8,
  localparam int LB_W  = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             disp_valid_i,
  input  logic [LB_W-1:0]  disp_lb_i,
  input  logic [IDX_W-1:0] disp_hidx_i,
  input  logic [BLK_W-1:0] disp_blk_i,
  input  logic             disp_unk_i,
  input  logic             disp_go_i,
  input  logic             disp_block_i,
  input  logic             st_valid_i,
  input  logic [BLK_W-1:0] st_blk_i,
  input  logic [DEPTH-1:0] st_younger_i,
  input  logic             ret_valid_i,
  input  logic [LB_W-1:0]  ret_lb_i,
  input  logic             flush_all_i,
  output logic             ret_upd_o,
  output logic             ret_rst_o,
  output logic             ret_done_o,
  output logic [IDX_W-1:0] ret_hidx_o,
  output logic [DEPTH-1:0] upd_o,
  output logic [DEPTH-1:0] done_o,
  output logic [DEPTH-1:0] rst_o,
  output logic [DEPTH-1:0] allow_o
);
  lb_flags_t        fl_q   [DEPTH];
  logic [IDX_W-1:0] hidx_q [DEPTH];
  logic [BLK_W-1:0] blk_q  [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic hit_disp, hit_ret, hit_st;
    assign hit_disp = disp_valid_i && disp_lb_i == LB_W'(e);
    assign hit_ret  = ret_valid_i && ret_lb_i == LB_W'(e);
    assign hit_st   = st_valid_i && st_younger_i[e] && fl_q[e].exec && blk_q[e] == st_blk_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        fl_q[e]   <= '0;
        hidx_q[e] <= '0;
        blk_q[e]  <= '0;
      end else if (flush_all_i || hit_ret) begin
        fl_q[e] <= '0;
      end else if (hit_disp) begin
        // re-dispatch of a live slot keeps its sticky bits
        fl_q[e].vld   <= 1'b1;
        fl_q[e].exec  <= ~disp_block_i;
        fl_q[e].allow <= disp_go_i;
        fl_q[e].upd   <= (fl_q[e].vld & fl_q[e].upd) | disp_unk_i;
        fl_q[e].done  <= (fl_q[e].vld & fl_q[e].done) | (disp_go_i & disp_unk_i);
        fl_q[e].rst   <= fl_q[e].vld & fl_q[e].rst;
        hidx_q[e]     <= disp_hidx_i;
        blk_q[e]      <= disp_blk_i;
      end else if (hit_st) begin
        fl_q[e].rst <= 1'b1;
      end
    end

    assign upd_o[e]   = fl_q[e].upd;
    assign done_o[e]  = fl_q[e].done;
    assign rst_o[e]   = fl_q[e].rst;
    assign allow_o[e] = fl_q[e].allow;
  end

  assign ret_upd_o  = fl_q[ret_lb_i].upd;
  assign ret_rst_o  = fl_q[ret_lb_i].rst;
  assign ret_done_o = fl_q[ret_lb_i].done;
  assign ret_hidx_o = hidx_q[ret_lb_i];
endmodule

// File: rtl/ldp_watchdog.sv
module ldp_watchdog #(
  parameter int WIN_LEN   = 1024,
  parameter int MAX_FLUSH = 8,
  localparam int CW       = $clog2(WIN_LEN),
  localparam int RW       = $clog2(MAX_FLUSH + 2)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ret_valid_i,
  input  logic restart_i,
  output logic disable_o
);
  logic [CW-1:0] win_q;
  logic [RW-1:0] hits_q, hits_nxt;
  logic          dis_q;

  // saturate one above the limit
  always_comb begin
    hits_nxt = hits_q;
    if (restart_i && hits_q <= RW'(MAX_FLUSH)) hits_nxt = hits_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      hits_q <= '0;
      dis_q  <= 1'b0;
    end else if (ret_valid_i) begin
      if (win_q == CW'(WIN_LEN - 1)) begin
        win_q  <= '0;
        hits_q <= '0;
        dis_q  <= hits_nxt > RW'(MAX_FLUSH);
      end else begin
        win_q  <= win_q + 1'b1;
        hits_q <= hits_nxt;
      end
    end
  end

  assign disable_o = dis_q;
endmodule

// File: rtl/ld_bypass_pred.sv
module ld_bypass_pred #(
  parameter int N_ENTRIES = 256,
  parameter int CNT_W     = 4,
  parameter int LB_DEPTH  = 16,
  parameter int ADDR_W    = 32,
  parameter int GRAN_LSB  = 3,
  parameter int WIN_LEN   = 1024,
  parameter int MAX_FLUSH = 8,
  localparam int IDX_W    = $clog2(N_ENTRIES),
  localparam int IP_W     = 2 * IDX_W,
  localparam int LB_W     = $clog2(LB_DEPTH),
  localparam int BLK_W    = ADDR_W - GRAN_LSB
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                disp_valid_i,
  input  logic [LB_W-1:0]     disp_lb_idx_i,
  input  logic [IP_W-1:0]     disp_ip_i,
  input  logic [BLK_W-1:0]    disp_blk_i,
  input  logic                disp_unk_i,
  output logic                disp_go_o,
  output logic                disp_block_o,
  input  logic                st_valid_i,
  input  logic [BLK_W-1:0]    st_blk_i,
  input  logic [LB_DEPTH-1:0] st_younger_i,
  input  logic                ret_valid_i,
  input  logic [LB_W-1:0]     ret_lb_idx_i,
  output logic                flush_o,
  output logic [LB_DEPTH-1:0] lb_upd_o,
  output logic [LB_DEPTH-1:0] lb_done_o,
  output logic [LB_DEPTH-1:0] lb_rst_o,
  output logic [LB_DEPTH-1:0] lb_allow_o,
  output logic                wd_disable_o
);
  logic [IDX_W-1:0] hidx, ret_hidx;
  logic sat, wd_dis, go, block;
  logic ret_upd, ret_rst, ret_done, restart, flush_q;

  assign hidx  = disp_ip_i[IDX_W-1:0] ^ disp_ip_i[IP_W-1:IDX_W];
  assign go    = sat & ~wd_dis;
  assign block = disp_unk_i & ~go;

  ldp_table #(.N_ENTRIES(N_ENTRIES), .CNT_W(CNT_W)) u_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_idx_i (hidx),
    .sat_o    (sat),
    .wr_en_i  (ret_valid_i & ret_upd),
    .wr_clr_i (ret_rst),
    .wr_idx_i (ret_hidx)
  );

  ldp_lbuf #(.DEPTH(LB_DEPTH), .BLK_W(BLK_W), .IDX_W(IDX_W)) u_lbuf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .disp_valid_i (disp_valid_i),
    .disp_lb_i    (disp_lb_idx_i),
    .disp_hidx_i  (hidx),
    .disp_blk_i   (disp_blk_i),
    .disp_unk_i   (disp_unk_i),
    .disp_go_i    (go),
    .disp_block_i (block),
    .st_valid_i   (st_valid_i),
    .st_blk_i     (st_blk_i),
    .st_younger_i (st_younger_i),
    .ret_valid_i  (ret_valid_i),
    .ret_lb_i     (ret_lb_idx_i),
    .flush_all_i  (restart),
    .ret_upd_o    (ret_upd),
    .ret_rst_o    (ret_rst),
    .ret_done_o   (ret_done),
    .ret_hidx_o   (ret_hidx),
    .upd_o        (lb_upd_o),
    .done_o       (lb_done_o),
    .rst_o        (lb_rst_o),
    .allow_o      (lb_allow_o)
  );

  assign restart = ret_valid_i & ret_done & ret_rst;

  ldp_watchdog #(.WIN_LEN(WIN_LEN), .MAX_FLUSH(MAX_FLUSH)) u_wd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ret_valid_i (ret_valid_i),
    .restart_i   (restart),
    .disable_o   (wd_dis)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flush_q <= 1'b0;
    else         flush_q <= restart;
  end

  assign disp_go_o    = go;
  assign disp_block_o = block;
  assign flush_o      = flush_q;
  assign wd_disable_o = wd_dis;
endmodule

// File: rtl/ld_bypass_pred_chk.sv
module ld_bypass_pred_chk #(
  parameter int LB_DEPTH = 16,
  parameter int LB_W     = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                disp_valid_i,
  input logic                disp_unk_i,
  input logic                disp_go_o,
  input logic                disp_block_o,
  input logic                ret_valid_i,
  input logic [LB_W-1:0]     ret_lb_idx_i,
  input logic                flush_o,
  input logic [LB_DEPTH-1:0] lb_upd_o,
  input logic [LB_DEPTH-1:0] lb_done_o,
  input logic [LB_DEPTH-1:0] lb_rst_o,
  input logic                wd_disable_o
);
  p_go_block_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(disp_go_o && disp_block_o));

  p_block_needs_unk_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_valid_i && disp_block_o) |-> disp_unk_i);

  p_wd_gates_go_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_disable_o |-> !disp_go_o);

  p_done_implies_upd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lb_done_o & ~lb_upd_o) == '0);

  p_flush_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> $past(ret_valid_i && lb_done_o[ret_lb_idx_i] && lb_rst_o[ret_lb_idx_i]));

  p_flush_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> (lb_upd_o == '0 && lb_done_o == '0 && lb_rst_o == '0));

  p_flush_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !flush_o);
endmodule

bind ld_bypass_pred ld_bypass_pred_chk #(.LB_DEPTH(LB_DEPTH), .LB_W(LB_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .disp_valid_i (disp_valid_i),
  .disp_unk_i   (disp_unk_i),
  .disp_go_o    (disp_go_o),
  .disp_block_o (disp_block_o),
  .ret_valid_i  (ret_valid_i),
  .ret_lb_idx_i (ret_lb_idx_i),
  .flush_o      (flush_o),
  .lb_upd_o     (lb_upd_o),
  .lb_done_o    (lb_done_o),
  .lb_rst_o     (lb_rst_o),
  .wd_disable_o (wd_disable_o)
);

// File: tb/ld_bypass_pred_bench.sv
`timescale 1ns/1ps
module ld_bypass_pred_bench;
  localparam int BW = 29;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk_i = ~clk_i;

  logic          disp_valid_i = 1'b0;
  logic [3:0]    disp_lb_idx_i = '0;
  logic [15:0]   disp_ip_i = '0;
  logic [BW-1:0] disp_blk_i = '0;
  logic          disp_unk_i = 1'b0;
  logic          disp_go_o, disp_block_o;
  logic          st_valid_i = 1'b0;
  logic [BW-1:0] st_blk_i = '0;
  logic [15:0]   st_younger_i = '0;
  logic          ret_valid_i = 1'b0;
  logic [3:0]    ret_lb_idx_i = '0;
  logic          flush_o, wd_disable_o;
  logic [15:0]   lb_upd_o, lb_done_o, lb_rst_o, lb_allow_o;

  ld_bypass_pred u_ld_bypass_pred (.*);

  int n_chk = 0, n_bad = 0, ret_cnt = 0;
  logic last_go, last_block, last_flush;

  localparam logic [15:0] IP_A = 16'h0102, IP_B = 16'h0300, IP_C = 16'h5555,
                          IP_D = 16'h2233, IP_H = 16'h00F0, IP_F = 16'h7777;
  localparam logic [BW-1:0] G1 = 29'h200, G2 = 29'h400;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic dispatch(int lb, logic [15:0] ip, logic [BW-1:0] blk, logic unk);
    @(negedge clk_i);
    disp_valid_i = 1'b1; disp_lb_idx_i = 4'(lb); disp_ip_i = ip;
    disp_blk_i = blk; disp_unk_i = unk;
    #1;
    last_go = disp_go_o; last_block = disp_block_o;
    @(posedge clk_i); #1;
    disp_valid_i = 1'b0; disp_unk_i = 1'b0;
  endtask

  task automatic store(logic [BW-1:0] blk, logic [15:0] younger);
    @(negedge clk_i);
    st_valid_i = 1'b1; st_blk_i = blk; st_younger_i = younger;
    @(posedge clk_i); #1;
    st_valid_i = 1'b0;
  endtask

  task automatic retire(int lb);
    @(negedge clk_i);
    ret_valid_i = 1'b1; ret_lb_idx_i = 4'(lb);
    @(posedge clk_i); #1;
    ret_valid_i = 1'b0;
    last_flush = flush_o;
    ret_cnt++;
  endtask

  task automatic train_step(logic [15:0] ip);
    dispatch(0, ip, G1, 1'b1);
    if (last_block) dispatch(0, ip, G1, 1'b0);
    retire(0);
  endtask

  task automatic filler();
    dispatch(1, IP_F, G2, 1'b0);
    retire(1);
  endtask

  task automatic pad_window();
    while (ret_cnt % 1024 != 0) filler();
  endtask

  task automatic restart_once(logic [15:0] ip);
    repeat (15) train_step(ip);
    dispatch(0, ip, G1, 1'b1);
    store(G1, 16'h0001);
    retire(0);
  endtask

  task automatic t_reset();
    #1;
    check("R1", disp_go_o, 0, "go after reset");
    check("R1", flush_o, 0, "flush after reset");
    check("R1", wd_disable_o, 0, "watchdog after reset");
    check("R1", {lb_upd_o, lb_done_o}, 0, "upd/done after reset");
    check("R1", {lb_rst_o, lb_allow_o}, 0, "rst/allow after reset");
  endtask

  task automatic t_train();
    for (int k = 0; k < 15; k++) begin
      dispatch(0, IP_A, G1, 1'b1);
      check("R3", {last_go, last_block}, 2'b01, "unsaturated lookup");
      if (k == 0) begin
        check("R4", lb_upd_o[0], 1, "update bit on unknown store");
        check("R4", lb_done_o[0], 0, "done bit when blocked");
      end
      dispatch(0, IP_A, G1, 1'b0);
      retire(0);
      if (k == 0) check("R4", lb_upd_o[0], 0, "slot cleared at retire");
    end
    for (int k = 0; k < 6; k++) begin
      dispatch(0, IP_A, G1, 1'b1);
      check("R6", {last_go, last_block}, 2'b10, "saturated counter holds go");
      if (k == 0) begin
        check("R4", lb_done_o[0], 1, "done bit on go");
        check("R4", lb_allow_o[0], 1, "allow bit on go");
      end
      retire(0);
    end
  endtask

  task automatic t_alias();
    dispatch(2, IP_B, G2, 1'b1);
    check("R2", last_go, 1, "aliased pointer shares saturated entry");
    retire(2);
  endtask

  task automatic t_collision_flush();
    dispatch(0, IP_A, G1, 1'b1);
    check("R3", last_go, 1, "go before collision");
    store(G2, 16'h0001);
    check("R5", lb_rst_o[0], 0, "other block leaves reset bit");
    store(G1, 16'h0000);
    check("R5", lb_rst_o[0], 0, "older load not compared");
    store(G1, 16'h0001);
    check("R5", lb_rst_o[0], 1, "matching younger executed load");
    retire(0);
    check("R9", last_flush, 1, "flush after bypass collision");
    check("R9", {lb_upd_o, lb_done_o, lb_rst_o}, 0, "status array cleared on flush");
    dispatch(0, IP_A, G1, 1'b1);
    check("R7", last_go, 0, "counter cleared by collision");
    check("R9", flush_o, 0, "flush lasts one cycle");
    dispatch(0, IP_A, G1, 1'b0);
    retire(0);
  endtask

  task automatic t_no_update();
    repeat (14) train_step(IP_C);
    repeat (5) begin
      dispatch(3, IP_C, G2, 1'b0);
      retire(3);
    end
    dispatch(0, IP_C, G1, 1'b1);
    check("R8", last_go, 0, "loads without unknown store leave counter");
    dispatch(0, IP_C, G1, 1'b0);
    retire(0);
    dispatch(0, IP_C, G1, 1'b1);
    check("R6", last_go, 1, "fifteenth increment saturates");
    retire(0);
  endtask

  task automatic t_blocked_collision();
    repeat (14) train_step(IP_D);
    dispatch(2, IP_D, G1, 1'b1);
    check("R3", last_block, 1, "unsaturated blocks");
    store(G1, 16'h0004);
    check("R5", lb_rst_o[2], 0, "blocked load not compared");
    dispatch(2, IP_D, G1, 1'b0);
    store(G1, 16'h0004);
    check("R5", lb_rst_o[2], 1, "executed load collides");
    check("R7", lb_done_o[2], 0, "collided load not bypassed");
    retire(2);
    check("R9", last_flush, 0, "no flush without bypass");
    dispatch(2, IP_D, G1, 1'b1);
    check("R7", last_go, 0, "collision clears counter without bypass");
    dispatch(2, IP_D, G1, 1'b0);
    retire(2);
  endtask

  task automatic t_watchdog();
    pad_window();
    check("R10", wd_disable_o, 0, "clean window");
    repeat (8) restart_once(IP_H);
    pad_window();
    check("R10", wd_disable_o, 0, "eight flushes in window");
    repeat (9) restart_once(IP_H);
    pad_window();
    check("R10", wd_disable_o, 1, "nine flushes in window");
    repeat (15) train_step(IP_H);
    dispatch(0, IP_H, G1, 1'b1);
    check("R10", {last_go, last_block}, 2'b01, "go withheld while disabled");
    dispatch(0, IP_H, G1, 1'b0);
    retire(0);
    pad_window();
    check("R10", wd_disable_o, 0, "disable lifts after a clean window");
    dispatch(0, IP_H, G1, 1'b1);
    check("R10", last_go, 1, "go returns after window");
    retire(0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    t_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_train();
    t_alias();
    t_collision_flush();
    t_no_update();
    t_blocked_collision();
    t_watchdog();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule